// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits beside a small 8-bit processor core and decides which of twelve peripheral interrupt requests the core takes next. Each source has an enable bit of its own and a two-bit priority, so there are four levels. A global enable gates every source at once. The core pulses an instruction-boundary strobe. On that strobe the arbiter picks the best pending, enabled source that may preempt the code now running, and offers its vector index and level to the core on a valid/ready channel.

The arbiter keeps a four-bit in-service set with one bit per priority level. Accepting a request sets the bit for that request's level. A return strobe from the core clears the highest set bit. The running level is the highest set bit. A request can only interrupt code running at a strictly lower level, so code at level 3 cannot be interrupted. Pending flags are owned by the peripherals, and this block never clears them.

The request channel follows these back-pressure rules. Once `irq_valid` is high, `irq_vector` and `irq_level` stay fixed until a cycle in which `irq_ready` is also high. No new arbitration takes place while a request is outstanding. `irq_valid` drops in the cycle after the handshake.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all enables, the global enable, all priorities and the in-service set are zero, `irq_valid` is low and `run_active` is low.
- R2: A write to address 0 sets the enable bits of sources 0..7 (data bit n is source n). A write to address 1 sets the enable bits of sources 8..11 (data bits 0..3). A source whose enable bit is 0 is never offered.
- R3: Bit 7 of address 1 is the global enable. While it is 0, no source is offered, whatever the individual enables are.
- R4: The level of a source is {high bit, low bit}. Low bits are written at addresses 2 (sources 0..7) and 3 (sources 8..11). High bits are written at addresses 4 and 5, using the same bit positions as the enables. Bits with no source behind them are ignored.
- R5: Among eligible pending sources, one with a higher level wins over one with a lower level.
- R6: Among eligible pending sources at the same level, the lowest source index wins.
- R7: A source is eligible only if its level is strictly above the running level, or if nothing is in service. Nothing preempts level 3.
- R8: Arbitration happens only in a cycle where `instr_bnd` is high and no request is outstanding. `irq_valid` rises in the next cycle. While `irq_valid` is high and `irq_ready` is low, the vector and level stay unchanged.
- R9: A handshake (`irq_valid` and `irq_ready` both high) sets the in-service bit of the offered level. `run_level` is the highest set bit and `run_active` is its OR.
- R10: A `reti` pulse clears the highest set in-service bit. When the set is empty, `reti` has no effect.
- R11: When a handshake and `reti` fall in the same cycle, the clear acts on the set as it stood before that cycle, and the new level's bit is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address (0..5) |
| cfg_wdata | input | 8 | Configuration write data |
| irq_pend | input | 12 | Pending flags from the sources, bit n = source n |
| instr_bnd | input | 1 | Instruction boundary strobe from the core |
| irq_valid | output | 1 | A request is offered to the core |
| irq_ready | input | 1 | The core accepts the offered request |
| irq_vector | output | 4 | Index of the offered source |
| irq_level | output | 2 | Priority level of the offered source |
| reti | input | 1 | Return-from-interrupt strobe |
| run_active | output | 1 | At least one level is in service |
| run_level | output | 2 | Highest level in service (0 when none) |

## Verification
The collision of interest is a return strobe in the same cycle as an accepted request. One level must be popped while another is pushed, and the order of the two decides the resulting running level. The bench sets this up directly: level 0 is in service, a level-3 request is outstanding, and `irq_ready` and `reti` are raised together. It then expects `run_level` to read 3, and the set to be empty after one more return. Random stimulus also raises `reti` alongside handshakes throughout the run, and a cycle-level reference model of the in-service set judges each one.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  // Index of the highest set bit in an in-service set; zero when empty.
  function automatic lvl_t top_level(input logic [NLVL-1:0] set);
    lvl_t r;
    r = '0;
    for (int k = 0; k < NLVL; k++) begin
      if (set[k]) r = lvl_t'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_nest_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int BANK_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      addr,
  input  logic [7:0]      wdata,
  output logic [NSRC-1:0] en,
  output logic            glob,
  output lvl_t            lvl [NSRC]
);
  localparam int GLOB_BIT = 7;
  localparam logic [2:0] A_EN = 3'd0;
  localparam logic [2:0] A_PL = 3'd2;
  localparam logic [2:0] A_PH = 3'd4;

  logic [NSRC-1:0] plo, phi;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      localparam logic [2:0] BK = 3'(i / BANK_W);
      localparam int         BT = i % BANK_W;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en[i]  <= 1'b0;
          plo[i] <= 1'b0;
          phi[i] <= 1'b0;
        end else if (wr) begin
          if (addr == A_EN + BK) en[i]  <= wdata[BT];
          if (addr == A_PL + BK) plo[i] <= wdata[BT];
          if (addr == A_PH + BK) phi[i] <= wdata[BT];
        end
      end
      assign lvl[i] = {phi[i], plo[i]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                            glob <= 1'b0;
    else if (wr && addr == A_EN + 3'd1)    glob <= wdata[GLOB_BIT];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int VW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic            glob,
  input  lvl_t            lvl [NSRC],
  input  logic            busy,
  input  lvl_t            cur,
  output logic            win_any,
  output logic [VW-1:0]   win_idx,
  output lvl_t            win_lvl
);
  logic [NSRC-1:0] elig;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_elig
      assign elig[i] = glob && en[i] && pend[i] && (!busy || lvl[i] > cur);
    end
  endgenerate

  // Ascending scan with strict compare: higher level wins, ties keep lowest index.
  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (!win_any || lvl[s] > win_lvl)) begin
        win_any = 1'b1;
        win_idx = VW'(s);
        win_lvl = lvl[s];
      end
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  lvl_t            push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] set_q,
  output logic            busy,
  output lvl_t            cur
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    nxt = set_q;
    if (pop && busy) nxt[cur] = 1'b0;
    if (push)        nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) set_q <= '0;
    else        set_q <= nxt;
  end

  assign busy = |set_q;
  assign cur  = top_level(set_q);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic [NSRC-1:0] irq_pend,
  input  logic            instr_bnd,
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [VW-1:0]   irq_vector,
  output logic [LVL_W-1:0] irq_level,
  input  logic            reti,
  output logic            run_active,
  output logic [LVL_W-1:0] run_level
);
  logic [NSRC-1:0] en;
  logic            glob_en;
  lvl_t            lvl [NSRC];
  logic            win_any;
  logic [VW-1:0]   win_idx;
  lvl_t            win_lvl;
  logic [NLVL-1:0] isr_vec;
  logic            busy;
  lvl_t            cur;
  logic            hs;

  irq_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .glob(glob_en), .lvl(lvl)
  );

  irq_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
    .pend(irq_pend), .en(en), .glob(glob_en), .lvl(lvl), .busy(busy), .cur(cur),
    .win_any(win_any), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign hs = irq_valid && irq_ready;

  irq_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .push(hs), .push_lvl(irq_level), .pop(reti),
    .set_q(isr_vec), .busy(busy), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else if (hs) begin
      irq_valid  <= 1'b0;
    end else if (!irq_valid && instr_bnd && win_any) begin
      irq_valid  <= 1'b1;
      irq_vector <= win_idx;
      irq_level  <= win_lvl;
    end
  end

  assign run_active = busy;
  assign run_level  = cur;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int VW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid,
  input logic          ready,
  input logic [VW-1:0] vec,
  input logic [1:0]    lvl,
  input logic          reti,
  input logic [3:0]    isr,
  input logic          run_active,
  input logic [1:0]    run_level,
  input logic          glob
);
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(vec) && $stable(lvl));

  a_r7_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (!run_active || lvl > run_level));

  a_r9_ack_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> run_active && run_level == $past(lvl));

  a_r10_return_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(valid && ready) && (isr != 4'd0) |=>
      ($countones(isr) + 1) == $past($countones(isr)));

  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(glob));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(irq_valid), .ready(irq_ready),
  .vec(irq_vector), .lvl(irq_level), .reti(reti), .isr(isr_vec),
  .run_active(run_active), .run_level(run_level), .glob(glob_en)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [N-1:0] irq_pend = '0;
  logic instr_bnd = 1'b0;
  logic irq_ready = 1'b0;
  logic reti = 1'b0;
  logic irq_valid;
  logic [3:0] irq_vector;
  logic [1:0] irq_level;
  logic run_active;
  logic [1:0] run_level;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [N-1:0] m_en = '0, m_plo = '0, m_phi = '0;
  logic m_glob = 1'b0;
  logic m_valid = 1'b0;
  logic [3:0] m_vec = '0;
  logic [1:0] m_lvl = '0;
  logic [3:0] m_isr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .irq_pend(irq_pend), .instr_bnd(instr_bnd),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .irq_level(irq_level), .reti(reti), .run_active(run_active),
    .run_level(run_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hi_of(input logic [3:0] s);
    int r = -1;
    for (int k = 3; k >= 0; k--) if (s[k] && r < 0) r = k;
    return r;
  endfunction

  function automatic int src_lvl(input int s);
    return {m_phi[s], m_plo[s]};
  endfunction

  // Best candidate: returns index or -1.
  function automatic int pick(input logic [N-1:0] pend);
    int best = -1;
    int run = hi_of(m_isr);
    for (int s = N - 1; s >= 0; s--) begin
      if (m_glob && m_en[s] && pend[s] && src_lvl(s) > run) begin
        if (best < 0 || src_lvl(s) >= src_lvl(best)) best = s;
      end
    end
    return best;
  endfunction

  // One clock: advance the model from driven inputs, then compare outputs.
  task automatic cyc(input string tag);
    logic hs;
    logic [3:0] isr_n;
    int w;
    int h;
    hs = m_valid && irq_ready;
    isr_n = m_isr;
    h = hi_of(m_isr);
    if (reti && h >= 0) isr_n[h] = 1'b0;
    if (hs) isr_n[m_lvl] = 1'b1;
    w = pick(irq_pend);
    if (hs) m_valid = 1'b0;
    else if (!m_valid && instr_bnd && w >= 0) begin
      m_valid = 1'b1;
      m_vec = 4'(w);
      m_lvl = 2'(src_lvl(w));
    end
    m_isr = isr_n;
    if (cfg_wr) begin
      for (int s = 0; s < N; s++) begin
        if (cfg_addr == 3'(s / 8))     m_en[s]  = cfg_wdata[s % 8];
        if (cfg_addr == 3'(2 + s / 8)) m_plo[s] = cfg_wdata[s % 8];
        if (cfg_addr == 3'(4 + s / 8)) m_phi[s] = cfg_wdata[s % 8];
      end
      if (cfg_addr == 3'd1) m_glob = cfg_wdata[7];
    end
    @(negedge clk);
    check({tag, " R8 valid"}, int'(irq_valid), int'(m_valid));
    if (m_valid) begin
      check({tag, " R5/R6 vector"}, int'(irq_vector), int'(m_vec));
      check({tag, " R4 level"}, int'(irq_level), int'(m_lvl));
    end
    check({tag, " R9 active"}, int'(run_active), int'(m_isr != 0));
    check({tag, " R10 run_level"}, int'(run_level), m_isr != 0 ? hi_of(m_isr) : 0);
  endtask

  task automatic idle();
    cfg_wr = 0; instr_bnd = 0; irq_ready = 0; reti = 0;
  endtask

  task automatic wcfg(input logic [2:0] a, input logic [7:0] d, input string tag);
    idle();
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    cyc(tag);
    cfg_wr = 0;
  endtask

  task automatic bnd(input logic [N-1:0] p, input string tag);
    idle();
    irq_pend = p; instr_bnd = 1;
    cyc(tag);
    instr_bnd = 0;
  endtask

  task automatic ack(input logic with_reti, input string tag);
    idle();
    irq_ready = 1; reti = with_reti;
    cyc(tag);
    irq_ready = 0; reti = 0;
  endtask

  task automatic ret(input string tag);
    idle();
    reti = 1;
    cyc(tag);
    reti = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", int'(irq_valid), 0);
    check("R1 active after reset", int'(run_active), 0);

    bnd('1, "R2 enables clear");
    bnd('1, "R2 enables clear 2");
    check("R2 no offer with enables clear", int'(irq_valid), 0);

    wcfg(3'd0, 8'hFF, "cfg");
    wcfg(3'd1, 8'h0F, "cfg");
    bnd('1, "R3 global off");
    bnd('1, "R3 global off 2");
    check("R3 no offer with global off", int'(irq_valid), 0);

    wcfg(3'd1, 8'h8F, "cfg");
    bnd('1, "R6 tie");
    check("R6 lowest index wins tie", int'(irq_vector), 0);
    check("R6 level 0", int'(irq_level), 0);
    ack(0, "R9 ack");
    check("R9 running level 0", int'(run_level), 0);
    ret("R10 pop");
    check("R10 pop empties", int'(run_active), 0);
    ret("R10 empty reti");
    check("R10 reti on empty no effect", int'(run_active), 0);

    wcfg(3'd3, 8'h08, "cfg");
    wcfg(3'd5, 8'h08, "cfg");
    bnd('1, "R5 high level");
    check("R5 level 3 source wins", int'(irq_vector), 11);
    check("R4 split bits form level 3", int'(irq_level), 3);
    ack(0, "R9 ack3");
    bnd('1, "R7 no preempt of 3");
    bnd('1, "R7 no preempt of 3 b");
    check("R7 level 3 not preempted", int'(irq_valid), 0);
    ret("R10 pop3");

    wcfg(3'd1, 8'h87, "cfg");
    bnd('1, "R2 src11 off");
    check("R2 disabled source skipped", int'(irq_vector), 0);
    ack(0, "ack0");
    bnd(12'h001, "R7 same level");
    check("R7 equal level cannot preempt", int'(irq_valid), 0);
    wcfg(3'd1, 8'h8F, "cfg");
    bnd('1, "R7 preempt");
    check("R7 higher level preempts", int'(irq_vector), 11);
    irq_pend = 12'h001; instr_bnd = 1;
    cyc("R8 hold");
    irq_pend = '0;
    cyc("R8 hold 2");
    check("R8 vector stable under back-pressure", int'(irq_vector), 11);
    ack(1, "R11 collide");
    check("R11 new level set after pop", int'(run_level), 3);
    ret("R11 pop");
    check("R11 set empty after one more return", int'(run_active), 0);

    for (int n = 0; n < 3000; n++) begin
      idle();
      irq_pend = N'($urandom());
      instr_bnd = ($urandom() % 2) == 0;
      irq_ready = ($urandom() % 5) < 2;
      reti = ($urandom() % 7) == 0;
      if (($urandom() % 10) == 0) begin
        cfg_wr = 1;
        cfg_addr = 3'($urandom() % 6);
        cfg_wdata = 8'($urandom());
        if (cfg_addr == 3'd1 && ($urandom() % 5) != 0) cfg_wdata[7] = 1'b1;
      end
      cyc("R5/R6/R7/R11 random");
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule